// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block is the central scheduler of an N x N input-queued crossbar switch in which every input keeps a separate cell queue for each output. A strobe marks the start of each cell slot. With that strobe, the block captures a flag matrix that shows which input queues hold cells for which outputs. It then runs a fixed number of request/grant/accept rounds, one round per clock, and builds a match in which each input is paired with at most one output and each output with at most one input. When the last round completes, the finished match is registered and announced with a single-cycle valid pulse, ready to configure the crossbar for that slot.

Each output keeps a grant pointer and each input keeps an accept pointer. Both pointers move only when the first round of a slot produces an accepted pairing. A connection made in the first round therefore drops to the lowest priority in the next slot. This keeps every queue from being starved. Under full load, the pairings settle into a rotation in which each input/output pair is served once every N slots.

Top module: `rr_xbar_matcher`

## Requirements
- R1: A slot begins when `cellStart` is high and the block is idle. At that clock edge `voqReq` is captured. Bit i*NUM_PORTS+j set means input i holds a cell for output j. Changes to `voqReq` at any other time do not affect the result.
- R2: In each round, every output that has live requests grants exactly one input: the first requester found by scanning upward, with wrap-around, starting at that output's grant pointer.
- R3: In each round, every input that receives grants accepts exactly one: the first granting output found by scanning upward, with wrap-around, starting at that input's accept pointer.
- R4: An output's grant pointer moves to one past the input it granted, modulo NUM_PORTS, only if that grant was accepted in the first round of the slot. Otherwise it keeps its value.
- R5: An input's accept pointer moves to one past the output it accepted, modulo NUM_PORTS, only on an accept in the first round of the slot. Otherwise it keeps its value.
- R6: Later rounds consider only inputs and outputs left unmatched by earlier rounds. In `matchOut`, each input row (bits i*NUM_PORTS through i*NUM_PORTS+NUM_PORTS-1) and each output column is one-hot or zero.
- R7: When ITERS equals NUM_PORTS, the match is maximal: no captured request exists whose input and output are both unmatched.
- R8: `matchValid` goes high for exactly one cycle, ITERS clock edges after the capturing edge. `matchOut` changes at that same edge and then holds until the next result.
- R9: After reset, `matchValid` and `matchOut` are 0, and all grant and accept pointers are 0.
- R10: A `cellStart` that arrives while rounds are in progress is ignored. It neither restarts the slot nor changes its result.
- R11: With every queue non-empty in every slot, the block settles to a full match each slot. Each input/output pair is then served exactly once in every NUM_PORTS consecutive slots.
- R12: `matchOut` pairs only an input and output whose request bit was set in the captured matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellStart | input | 1 | Slot start strobe, accepted only when idle |
| voqReq | input | NUM_PORTS*NUM_PORTS | Queue non-empty flags, bit i*NUM_PORTS+j = input i toward output j |
| matchOut | output | NUM_PORTS*NUM_PORTS | Registered match, same bit layout, one-hot-or-zero per row and per column |
| matchValid | output | 1 | One-cycle pulse when `matchOut` carries a new slot's match |

## Verification
The assertions assume that a new slot is requested only after the previous valid pulse. The ignored-strobe check assumes that a strobe seen while busy simply disappears. The maximality property is built only when the round count equals the port count, because fewer rounds may legitimately leave a free pair. The stimulus starts each slot on the cycle after the previous result has been observed to hold. In some slots it drives a stray strobe and a different request matrix while the rounds run, to confirm that both have no effect. The behavioural model in the bench replays the pointer rules, and every output is compared on every clock.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  // strobes from the round sequencer to the match datapath
  typedef struct packed {
    logic load;    // capture requests, clear round state
    logic step;    // perform one request/grant/accept round
    logic first;   // this round may move pointers
    logic finish;  // last round: publish the match
  } mstep_t;
endpackage

// File: rtl/xbm_ctrl.sv
module xbm_ctrl
  import xbm_pkg::*;
#(
  parameter int ITERS = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cellStart,
  output mstep_t ctl,
  output logic   matchValid
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  logic          busy;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl.load   = cellStart && !busy;
    ctl.step   = busy;
    ctl.first  = busy && (iterCnt == '0);
    ctl.finish = busy && (iterCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      iterCnt    <= '0;
      matchValid <= 1'b0;
    end else begin
      matchValid <= ctl.finish;
      if (ctl.load) begin
        busy    <= 1'b1;
        iterCnt <= '0;
      end else if (ctl.finish) begin
        busy    <= 1'b0;
      end else if (busy) begin
        iterCnt <= iterCnt + 1'b1;
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |=> !matchValid);

  // R10
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cellStart && !ctl.finish) |=> (busy && !ctl.first));
endmodule

// File: rtl/xbm_path.sv
module xbm_path
  import xbm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ITERS     = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  mstep_t                         ctl,
  input  logic [NUM_PORTS*NUM_PORTS-1:0] reqIn,
  output logic [NUM_PORTS*NUM_PORTS-1:0] matchOut
);
  localparam int N  = NUM_PORTS;
  localparam int NN = N * N;
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [NN-1:0]          reqReg, matchAcc, accMat;
  logic [N-1:0]           inDone, outDone, colHit;
  logic [N-1:0][PW-1:0]   gPtr, aPtr;
  logic [N-1:0][N-1:0]    grCand, acCand;
  logic [N-1:0][PW:0]     grPick, acPick;

  // first set bit of cand at or after ptr, wrapping; MSB = found
  function automatic logic [PW:0] rrPick(input logic [N-1:0] cand,
                                         input logic [PW-1:0] ptr);
    logic [PW:0] res;
    int idx;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(ptr) + k) % N;
      if (cand[idx]) res = {1'b1, PW'(idx)};
    end
    return res;
  endfunction

  function automatic logic [PW-1:0] nextPos(input logic [PW-1:0] v);
    return (int'(v) == N - 1) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    // grant stage, per output
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++)
        grCand[j][i] = reqReg[i*N+j] && !inDone[i] && !outDone[j];
      grPick[j] = rrPick(grCand[j], gPtr[j]);
    end
    // accept stage, per input
    accMat = '0;
    colHit = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++)
        acCand[i][j] = grPick[j][PW] && (grPick[j][PW-1:0] == PW'(i));
      acPick[i] = rrPick(acCand[i], aPtr[i]);
      if (acPick[i][PW]) begin
        accMat[i*N + int'(acPick[i][PW-1:0])] = 1'b1;
        colHit[acPick[i][PW-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg   <= '0;
      matchAcc <= '0;
      matchOut <= '0;
      inDone   <= '0;
      outDone  <= '0;
      gPtr     <= '0;
      aPtr     <= '0;
    end else if (ctl.load) begin
      reqReg   <= reqIn;
      matchAcc <= '0;
      inDone   <= '0;
      outDone  <= '0;
    end else if (ctl.step) begin
      matchAcc <= matchAcc | accMat;
      outDone  <= outDone | colHit;
      for (int i = 0; i < N; i++) begin
        if (acPick[i][PW]) begin
          inDone[i] <= 1'b1;
          if (ctl.first) begin
            aPtr[i]                  <= nextPos(acPick[i][PW-1:0]);
            gPtr[acPick[i][PW-1:0]]  <= nextPos(PW'(i));
          end
        end
      end
      if (ctl.finish) matchOut <= matchAcc | accMat;
    end
  end

  // ---------------- checks ----------------
  logic [N-1:0][N-1:0] outCols;
  logic [N-1:0]        rowBusy, colBusy;
  logic [NN-1:0]       freePair;
  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        outCols[j][i] = matchOut[i*N+j];
    for (int i = 0; i < N; i++) rowBusy[i] = |matchOut[i*N +: N];
    for (int j = 0; j < N; j++) colBusy[j] = |outCols[j];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        freePair[i*N+j] = reqReg[i*N+j] && !rowBusy[i] && !colBusy[j];
  end

  for (genvar g = 0; g < N; g++) begin : g_oh
    // R6
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(matchOut[g*N +: N]));
    // R6
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(outCols[g]));
  end

  // R12
  subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.finish) |-> ((matchOut & ~reqReg) == '0));

  // R4
  gptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.step && ctl.first) |-> $stable(gPtr));

  // R5
  aptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.step && ctl.first) |-> $stable(aPtr));

  if (ITERS == NUM_PORTS) begin : g_max
    // R7
    maximal_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.finish) |-> (freePair == '0));
  end
endmodule

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher
  import xbm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ITERS     = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cellStart,
  input  logic [NUM_PORTS*NUM_PORTS-1:0] voqReq,
  output logic [NUM_PORTS*NUM_PORTS-1:0] matchOut,
  output logic                           matchValid
);
  mstep_t ctl;

  xbm_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cellStart  (cellStart),
    .ctl        (ctl),
    .matchValid (matchValid)
  );

  xbm_path #(.NUM_PORTS(NUM_PORTS), .ITERS(ITERS)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqIn    (voqReq),
    .matchOut (matchOut)
  );
endmodule

// File: tb/rr_xbar_matcher_test.sv
module rr_xbar_matcher_test;
  localparam int N  = 4;
  localparam int IT = 4;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cellStart = 1'b0;
  logic [NN-1:0] voqReq = '0;
  logic [NN-1:0] matchOut;
  logic          matchValid;

  int vectors = 0;
  int fails   = 0;
  int gp [N];
  int ap [N];
  logic [31:0] rng = 32'h1badb002;

  always #10 clk = ~clk;  // 50 MHz

  rr_xbar_matcher #(.NUM_PORTS(N), .ITERS(IT)) uut (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .voqReq(voqReq),
    .matchOut(matchOut), .matchValid(matchValid)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [NN-1:0] act, input logic [NN-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural replay of the round rules (R2..R6)
  task automatic refMatch(input logic [NN-1:0] r, output logic [NN-1:0] m);
    bit inM [N];
    bit outM [N];
    int g [N];
    int acc [N];
    m = '0;
    for (int i = 0; i < N; i++) begin inM[i] = 0; outM[i] = 0; end
    for (int it = 0; it < IT; it++) begin
      for (int j = 0; j < N; j++) begin
        g[j] = -1;
        for (int k = 0; k < N; k++) begin
          int i = (gp[j] + k) % N;
          if (g[j] < 0 && r[i*N+j] && !inM[i] && !outM[j]) g[j] = i;
        end
      end
      for (int i = 0; i < N; i++) begin
        acc[i] = -1;
        for (int k = 0; k < N; k++) begin
          int j = (ap[i] + k) % N;
          if (acc[i] < 0 && g[j] == i) acc[i] = j;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (acc[i] >= 0) begin
          m[i*N + acc[i]] = 1'b1;
          inM[i] = 1;
          outM[acc[i]] = 1;
          if (it == 0) begin
            gp[acc[i]] = (i + 1) % N;
            ap[i] = (acc[i] + 1) % N;
          end
        end
      end
    end
  endtask

  function automatic bit isMaximal(input logic [NN-1:0] r, input logic [NN-1:0] m);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N+j] && (m[i*N +: N] == '0)) begin
          bit colFree = 1;
          for (int q = 0; q < N; q++) if (m[q*N+j]) colFree = 0;
          if (colFree) return 0;
        end
    return 1;
  endfunction

  // called at a negedge; returns at the negedge after the hold check
  task automatic runCell(input logic [NN-1:0] r, input bit poke,
                         output logic [NN-1:0] got);
    logic [NN-1:0] exp;
    cellStart = 1'b1;
    voqReq    = r;
    @(negedge clk);
    cellStart = poke;        // R10: stray strobe while busy
    voqReq    = ~r;          // R1: later changes must not matter
    refMatch(r, exp);
    for (int k = 1; k <= IT; k++) begin
      @(negedge clk);
      cellStart = 1'b0;
      chk(matchValid == (k == IT), "R8 valid timing",
          NN'(matchValid), NN'(k == IT));
      if (k == IT) begin
        chk(matchOut == exp, poke ? "R10 match vs model" : "R2/R3 match vs model",
            matchOut, exp);
        chk((matchOut & ~r) == '0, "R12 subset of requests", matchOut, r);
        if (IT == N)
          chk(isMaximal(r, matchOut), "R7 maximal", matchOut, r);
      end
    end
    got = matchOut;
    @(negedge clk);
    chk(!matchValid && matchOut == got, "R8 pulse ends and match holds",
        matchOut, got);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [NN-1:0] m;
    int served [NN];
    for (int i = 0; i < N; i++) begin gp[i] = 0; ap[i] = 0; end
    repeat (3) @(negedge clk);
    // R9
    chk(matchValid == 1'b0 && matchOut == '0, "R9 reset state", matchOut, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3/R5: input 0 requests every output; accepts rotate 0,1,2,3
    for (int c = 0; c < N; c++) begin
      logic [NN-1:0] r0;
      r0 = '0;
      r0[N-1:0] = '1;
      runCell(r0, 1'b0, m);
      chk(m == NN'(1) << c, "R5 accept pointer rotation", m, NN'(1) << c);
    end

    // R2/R4: all inputs want output 0; grant pointer now 1 -> 1,2,3,0
    for (int c = 0; c < N; c++) begin
      logic [NN-1:0] rc;
      int w;
      rc = '0;
      for (int i = 0; i < N; i++) rc[i*N] = 1'b1;
      w = (c + 1) % N;
      runCell(rc, 1'b0, m);
      chk(m == NN'(1) << (w*N), "R4 grant pointer rotation", m, NN'(1) << (w*N));
    end

    // R6: diagonal and anti-diagonal patterns, all pairs disjoint
    begin
      logic [NN-1:0] d;
      d = '0;
      for (int i = 0; i < N; i++) d[i*N+i] = 1'b1;
      runCell(d, 1'b0, m);
      chk(m == d, "R6 diagonal full match", m, d);
      d = '0;
      for (int i = 0; i < N; i++) d[i*N + (N-1-i)] = 1'b1;
      runCell(d, 1'b1, m);
      chk(m == d, "R10 anti-diagonal with stray strobe", m, d);
    end

    // empty matrix
    runCell('0, 1'b0, m);
    chk(m == '0, "R12 no requests no match", m, '0);

    // pseudo-random matrices, some with stray strobes
    for (int c = 0; c < 40; c++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      runCell(NN'(rng), rng[20], m);
    end

    // R11: full load, settle, then each pair once per N slots
    for (int c = 0; c < 3 * N; c++) runCell('1, 1'b0, m);
    for (int p = 0; p < NN; p++) served[p] = 0;
    for (int c = 0; c < N; c++) begin
      runCell('1, 1'b0, m);
      chk($countones(m) == N, "R11 full match under load", m, '1);
      for (int p = 0; p < NN; p++) if (m[p]) served[p]++;
    end
    for (int p = 0; p < NN; p++)
      chk(served[p] == 1, "R11 pair served once per N slots",
          NN'(served[p]), NN'(1));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule